// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Command and Burst Front End

This block sits between the user pins of a synchronous flow-through SRAM and its storage core. On every rising clock edge that is not stalled it samples three chip-select levels, a write-enable level, an advance/load level, a flush qualifier and a 21-bit word address. It then decides whether the edge starts a new access, continues the current burst, or deselects the part.

An access fixes its operation, either read or write, and its base address on the load edge. Later advance edges step a two-bit beat counter, and the counter wraps after four beats. The two low core address bits follow a linear order or an interleaved order, chosen by a static mode input. Read data flows combinationally from the core word addressed by the registers loaded at the last edge. The block also gates the data-output enable and drives the core write strobe. A behavioural register array stands in for the core. It decodes only the low address bits.

Top module: `fts_ssram_front`

## Requirements
- R1: A load edge (cen_ni low, adv_ld_i low) selects the part only when sel0_ni is 0, sel1_i is 1 and sel2_ni is 0. Any other chip-select combination on a load edge deselects the part, and afterwards dq_oe_o and core_we_o are both 0.
- R2: An edge with cen_ni high changes no state. core_addr_o, core_we_o and the output gating are the same as they were before that edge.
- R3: On a selected load edge, core_addr_o takes the value of addr_i and the beat count returns to 0. While reading, rdata_o shows the array word at core_addr_o in the same cycle, with no extra register stage.
- R4: The operation (we_ni low means write) is captured on the load edge and holds for every beat. On advance edges (adv_ld_i high) we_ni and the chip selects are ignored.
- R5: With interleave_i = 0, core_addr_o[1:0] equals base plus beat count, modulo 4. A start of 01 gives 01, 10, 11, 00.
- R6: With interleave_i = 1, core_addr_o[1:0] equals base XOR beat count. A start of 01 gives 01, 00, 11, 10.
- R7: flush_i is sampled on every load or advance edge. When it is high during a write beat, that beat is a dummy: core_we_o stays 0 and the array keeps its contents. On a real write beat, core_we_o is 1 and wdata_i is stored at core_addr_o on the next edge with cen_ni low. Stalled edges do not store.
- R8: dq_oe_o is 1 only in a read beat with oe_ni low that is not the first beat after a deselected state. It is 0 during write beats and while deselected. rdata_o is 0 whenever dq_oe_o is 0.
- R9: After reset the part is deselected, with dq_oe_o and core_we_o at 0. An advance edge seen while deselected leaves it deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock qualifier, active low; high stalls the edge |
| sel0_ni | input | 1 | Chip select, active low |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write request on a load edge, active low |
| adv_ld_i | input | 1 | 0 loads a new command, 1 advances the burst |
| flush_i | input | 1 | High turns the current write beat into a dummy |
| interleave_i | input | 1 | Static burst-order select: 0 linear, 1 interleaved |
| addr_i | input | 21 | Word address sampled on load edges |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 32 | Write data for the current beat |
| rdata_o | output | 32 | Read data, zero when not driving |
| dq_oe_o | output | 1 | Data-bus drive enable |
| core_addr_o | output | 21 | Core word address of the current beat |
| core_we_o | output | 1 | Core write strobe for the current beat |

## Verification
The hardest state to reach from the ports is a stall that falls inside an interleaved burst and is followed by advance edges that carry conflicting write-enable and chip-select levels. Reaching it needs a run of several edges in a fixed order, so directed sequences build it explicitly. The first beat after a deselect is masked, so the directed read starts from a deselected state to make that mask visible. A dummy write is aimed at a word already holding known data, then read back to show the word is unchanged. A long seeded random phase then mixes loads, advances, stalls, deselects and flushes under both burst orders. Every cycle is compared against a reference model held in the bench.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_LOAD  = 2'd2,
    CMD_ADV   = 2'd3
  } cmd_e;

  function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] base,
                                                input logic [BEAT_W-1:0] cnt,
                                                input logic              ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
  import fts_pkg::*;
(
  input  logic cen_ni,
  input  logic sel0_ni,
  input  logic sel1_i,
  input  logic sel2_ni,
  input  logic adv_ld_i,
  input  logic active_i,
  output cmd_e cmd_o
);
  logic sel_ok;
  assign sel_ok = ~sel0_ni & sel1_i & ~sel2_ni;

  always_comb begin
    if (cen_ni)        cmd_o = CMD_HOLD;
    else if (!adv_ld_i) cmd_o = sel_ok ? CMD_LOAD : CMD_DESEL;
    else               cmd_o = active_i ? CMD_ADV : CMD_DESEL;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
  import fts_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              flush_i,
  input  logic              interleave_i,
  output logic              active_o,
  output logic              write_o,
  output logic              dummy_o,
  output logic              fresh_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      write_o  <= 1'b0;
      dummy_o  <= 1'b0;
      fresh_o  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          active_o <= 1'b1;
          write_o  <= ~we_ni;
          dummy_o  <= flush_i;
          fresh_o  <= ~active_o;
          base_q   <= addr_i;
          cnt_q    <= '0;
        end
        CMD_ADV: begin
          cnt_q   <= cnt_q + 1'b1;
          dummy_o <= flush_i;
          fresh_o <= 1'b0;
        end
        CMD_DESEL: begin
          active_o <= 1'b0;
          fresh_o  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[BEAT_W-1:0], cnt_q, interleave_i)};

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_HOLD && active_o) |=> ($stable(addr_o) && $stable(active_o) && $stable(write_o) && $stable(dummy_o))); // R2
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_LOAD) |=> (active_o && addr_o == $past(addr_i))); // R3
  AST_OP_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ADV) |=> (active_o && $stable(write_o))); // R4
  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ADV && !interleave_i) |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R5
  AST_ILV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ADV && interleave_i) |=>
      ((addr_o[1:0] ^ $past(addr_o[1:0])) == ($past(cnt_q) ^ ($past(cnt_q) + 2'd1)))); // R6
endmodule

// File: rtl/fts_mem_array.sv
module fts_mem_array #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/fts_ssram_front.sv
module fts_ssram_front
  import fts_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              sel0_ni,
  input  logic              sel1_i,
  input  logic              sel2_ni,
  input  logic              we_ni,
  input  logic              adv_ld_i,
  input  logic              flush_i,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic              core_we_o
);
  cmd_e              cmd;
  logic              active, write, dummy, fresh;
  logic [DATA_W-1:0] core_rdata;

  fts_cmd_decode u_dec (
    .cen_ni   (cen_ni),
    .sel0_ni  (sel0_ni),
    .sel1_i   (sel1_i),
    .sel2_ni  (sel2_ni),
    .adv_ld_i (adv_ld_i),
    .active_i (active),
    .cmd_o    (cmd)
  );

  fts_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .addr_i       (addr_i),
    .we_ni        (we_ni),
    .flush_i      (flush_i),
    .interleave_i (interleave_i),
    .active_o     (active),
    .write_o      (write),
    .dummy_o      (dummy),
    .fresh_o      (fresh),
    .addr_o       (core_addr_o)
  );

  assign core_we_o = active & write & ~dummy;
  assign dq_oe_o   = active & ~write & ~fresh & ~oe_ni;

  fts_mem_array #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (core_we_o & ~cen_ni),
    .addr_i  (core_addr_o[MEM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (core_rdata)
  );

  assign rdata_o = dq_oe_o ? core_rdata : '0;

  AST_BAD_SELECT_DESELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_ld_i && !(!sel0_ni && sel1_i && !sel2_ni)) |=> (!dq_oe_o && !core_we_o)); // R1
  AST_FLUSH_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd == CMD_LOAD || cmd == CMD_ADV) && flush_i) |=> !core_we_o); // R7
  AST_WRITE_BEAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we_o |-> !dq_oe_o); // R8
  AST_IDLE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && !active) |=> (!dq_oe_o && !core_we_o)); // R9
endmodule

// File: tb/fts_ssram_front_tb.sv
`timescale 1ns/1ps
module fts_ssram_front_tb;
  localparam int AW = 21, DW = 32, MAW = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cen_ni = 1'b1, sel0_ni = 1'b1, sel1_i = 1'b0, sel2_ni = 1'b1;
  logic we_ni = 1'b1, adv_ld_i = 1'b0, flush_i = 1'b0, ilv = 1'b0, oe_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic dq_oe_o, core_we_o;
  logic [AW-1:0] core_addr_o;

  always #2.5 clk = ~clk;

  fts_ssram_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .sel0_ni(sel0_ni), .sel1_i(sel1_i),
    .sel2_ni(sel2_ni), .we_ni(we_ni), .adv_ld_i(adv_ld_i), .flush_i(flush_i),
    .interleave_i(ilv), .addr_i(addr_i), .oe_ni(oe_ni), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .dq_oe_o(dq_oe_o), .core_addr_o(core_addr_o), .core_we_o(core_we_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic m_act = 0, m_wr = 0, m_dum = 0, m_fresh = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [DW-1:0] ref_mem [1<<MAW];
  bit ref_ok [1<<MAW];

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_oe;
    logic [MAW-1:0] idx;
    e_oe = m_act & ~m_wr & ~m_fresh & ~oe_ni;
    idx = exp_addr();
    chk("R8 dq_oe", 64'(dq_oe_o), 64'(e_oe));
    chk("R7 core_we", 64'(core_we_o), 64'(m_act & m_wr & ~m_dum));
    if (m_act) chk("R3 core_addr", 64'(core_addr_o), 64'(exp_addr()));
    if (!e_oe) chk("R8 rdata idle", 64'(rdata_o), 64'd0);
    else if (ref_ok[idx]) chk("R3 rdata", 64'(rdata_o), 64'(ref_mem[idx]));
  endtask

  // one clock: inputs already set at negedge by caller
  task automatic step();
    logic sel;
    @(posedge clk);
    if (rst_ni && !cen_ni) begin
      if (m_act && m_wr && !m_dum) begin
        ref_mem[exp_addr() & ((1<<MAW)-1)] = wdata_i;
        ref_ok[exp_addr() & ((1<<MAW)-1)] = 1'b1;
      end
      sel = ~sel0_ni & sel1_i & ~sel2_ni;
      if (!adv_ld_i) begin
        if (sel) begin
          m_fresh = ~m_act; m_act = 1; m_wr = ~we_ni; m_dum = flush_i; m_base = addr_i; m_cnt = 0;
        end else begin
          m_act = 0; m_fresh = 0;
        end
      end else if (m_act) begin
        m_cnt = m_cnt + 1; m_dum = flush_i; m_fresh = 0;
      end else begin
        m_act = 0; m_fresh = 0;
      end
    end
    #1;
    compare_all();
  endtask

  task automatic cyc(input logic cen, input logic adv, input logic sel_good, input logic we,
                     input logic fl, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    @(negedge clk);
    cen_ni = cen; adv_ld_i = adv; we_ni = we; flush_i = fl; addr_i = a; wdata_i = wd;
    sel0_ni = 1'b0; sel1_i = sel_good; sel2_ni = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  logic [1:0] lin_seq [4];
  logic [1:0] ilv_seq [4];

  initial begin
    int unsigned r;
    logic [AW-1:0] hold_addr;
    lin_seq = '{2'd1, 2'd2, 2'd3, 2'd0};
    ilv_seq = '{2'd1, 2'd0, 2'd3, 2'd2};
    for (int i = 0; i < (1<<MAW); i++) ref_ok[i] = 1'b0;
    r = $urandom(32'h5EED_0042);

    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset dq_oe", 64'(dq_oe_o), 64'd0);
    chk("R9 reset core_we", 64'(core_we_o), 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    // advance while deselected
    cyc(0, 1, 1, 0, 0, 21'h0, 32'h0);
    chk("R9 idle advance", 64'({dq_oe_o, core_we_o}), 64'd0);
    cyc(0, 1, 1, 1, 0, 21'h0, 32'h0);

    // linear write burst at 0x10
    ilv = 1'b0;
    cyc(0, 0, 1, 0, 0, 21'h10, 32'h0);
    cyc(0, 1, 1, 1, 0, 21'h0, 32'hA0A0_0000);
    cyc(0, 1, 1, 1, 0, 21'h0, 32'hA1A1_1111);
    cyc(0, 1, 1, 1, 0, 21'h0, 32'hA2A2_2222);
    // linear read at 0x11, writing last beat on this edge
    cyc(0, 0, 1, 1, 0, 21'h11, 32'hA3A3_3333);
    chk("R5 lin beat0", 64'(core_addr_o[1:0]), 64'(lin_seq[0]));
    chk("R3 flow-through read", 64'(rdata_o), 64'hA1A1_1111);
    for (int b = 1; b < 4; b++) begin
      cyc(0, 1, 1, 1, 0, 21'h0, 32'h0);
      chk("R5 lin beat", 64'(core_addr_o[1:0]), 64'(lin_seq[b]));
    end

    // deselect, switch order, interleaved read from deselected state
    cyc(0, 0, 0, 1, 0, 21'h0, 32'h0);
    ilv = 1'b1;
    cyc(0, 0, 1, 1, 0, 21'h11, 32'h0);
    chk("R8 first after deselect masked", 64'(dq_oe_o), 64'd0);
    chk("R6 ilv beat0", 64'(core_addr_o[1:0]), 64'(ilv_seq[0]));
    cyc(0, 1, 1, 1, 0, 21'h0, 32'h0);
    chk("R6 ilv beat1", 64'(core_addr_o[1:0]), 64'(ilv_seq[1]));
    hold_addr = core_addr_o;
    cyc(1, 1, 1, 0, 1, 21'h1FFFFF, 32'h0);
    cyc(1, 0, 1, 0, 1, 21'h1FFFFF, 32'h0);
    chk("R2 stall addr", 64'(core_addr_o), 64'(hold_addr));
    chk("R2 stall no strobe", 64'(core_we_o), 64'd0);
    // advance with we low and bad select: ignored
    cyc(0, 1, 0, 0, 0, 21'h0, 32'h0);
    chk("R6 ilv beat2", 64'(core_addr_o[1:0]), 64'(ilv_seq[2]));
    chk("R4 op kept read", 64'({dq_oe_o, core_we_o}), 64'b10);
    cyc(0, 1, 1, 0, 0, 21'h0, 32'h0);
    chk("R6 ilv beat3", 64'(core_addr_o[1:0]), 64'(ilv_seq[3]));

    // bad select on load with we low
    cyc(0, 0, 0, 0, 0, 21'h12, 32'h0);
    chk("R1 bad select", 64'({dq_oe_o, core_we_o}), 64'd0);

    // dummy write to 0x12 then read back
    ilv = 1'b0;
    cyc(0, 0, 1, 0, 1, 21'h12, 32'h0);
    chk("R7 dummy strobe", 64'(core_we_o), 64'd0);
    cyc(0, 0, 1, 1, 0, 21'h12, 32'hDEAD_BEEF);
    chk("R7 dummy kept data", 64'(rdata_o), 64'hA2A2_2222);

    // random phase
    for (int ph = 0; ph < 2; ph++) begin
      cyc(0, 0, 0, 1, 0, 21'h0, 32'h0);
      ilv = ph[0];
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        cen_ni   = ($urandom % 100) < 15;
        adv_ld_i = ($urandom % 100) < 55;
        we_ni    = $urandom % 2;
        flush_i  = ($urandom % 100) < 15;
        oe_ni    = ($urandom % 100) < 15;
        sel0_ni  = ($urandom % 100) < 8;
        sel1_i   = ($urandom % 100) >= 8;
        sel2_ni  = ($urandom % 100) < 8;
        addr_i   = 21'($urandom);
        wdata_i  = $urandom;
        step();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule